// File: doc/BRIEF.md
# Two-Way Set Associative Cache with Not-Recently-Used Replacement

This block is a write-back, write-allocate cache between a CPU and main memory. It is organised as two ways of eight lines each, and every line holds a block of two 32-bit words. Each line also carries three state bits: valid, dirty and a single reference bit. The reference bit drives a not-recently-used choice of which line to replace.

The CPU presents a word address, a read/write flag and write data, and holds the request until the cache answers. A hit answers in the same cycle. A miss stalls the CPU. If the line chosen for replacement holds modified data, the cache first writes that block back to memory. It then fetches the requested block from memory and completes the access from the refilled line.

The memory port moves whole two-word blocks. Each transfer is a request that stays up until memory acknowledges it.

Top module: `nru_cache2w`

## Requirements
- R1: A CPU word address is split as follows. Bit 0 selects the word in the block (0 = lower word). Bits 3:1 give the line index. Bits 31:4 are the tag. A read returns the word most recently written to that address, or the memory value if the address was never written.
- R2: A hit asserts `cpu_ready` in the same cycle as `cpu_req`, with the read data on `cpu_rdata`. A hit causes no memory transfer.
- R3: A miss keeps `cpu_ready` low until the refill completes. The refill is a single block read at word address {tag, index, 0}. After the refill, the access completes as a hit.
- R4: A write, whether a hit or after its allocating refill, stores the word and marks the line dirty.
- R5: Using a line sets its reference bit. The same use clears the reference bit of the line at the same index in the other way.
- R6: The victim is chosen in this order. First, an invalid line, with way 0 before way 1. Otherwise, the way whose reference bit is 0. If no way has a reference bit of 0, way 0 is chosen.
- R7: A victim that is valid and dirty is written back as one block write before the refill read. The write goes to {victim tag, index, 0} and carries the victim's two words.
- R8: After a synchronous active-low reset, every line is invalid, clean, unreferenced and zero. No memory request is pending and `cpu_ready` is low.
- R9: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable from the moment a request is raised until the cycle in which `mem_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Word address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes at this clock edge |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 32 | Word address of the block (bit 0 = 0) |
| mem_wdata | output | 64 | Block to write; word 0 in bits 31:0 |
| mem_rdata | input | 64 | Block read; word 0 in bits 31:0 |
| mem_ack | input | 1 | One-cycle acknowledge of the pending request |

## Verification
The bench goes after the victim choice when an index is full. A picker that ignored the reference bit, or broke ties toward way 1, would evict the line just used; the bench sees this as an unexpected miss or a write-back at the wrong address. It checks write-backs of dirty victims for address, data and order. A design that forgot the dirty bit would drop written data, and one that refilled first would read stale memory. It also checks the latency difference between hits and misses. Random traffic over four tags per index, with a varying memory delay, keeps every index under eviction pressure.

// File: rtl/cache2w_pkg.sv
// Shared types for the two-way cache: controller states and per-line state bits.
package cache2w_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cstate_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic refb;
    } line_meta_t;
endpackage

// File: rtl/way_store.sv
// One way of the cache: state bits, tag and two-word block for every line.
// Assumes all operations in a cycle target the line at idx. Fill and use
// never coincide; the controller guarantees this.
module way_store
    import cache2w_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int TAG_W  = 28,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    idx,
    output line_meta_t          meta_o,
    output logic [TAG_W-1:0]    tag_o,
    output logic [2*DATA_W-1:0] blk_o,
    input  logic                fill_en,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic [2*DATA_W-1:0] fill_blk,
    input  logic                use_en,
    input  logic                clr_ref,
    input  logic                wr_en,
    input  logic                wr_word,
    input  logic [DATA_W-1:0]   wr_data
);
    localparam int LINES = 1 << IDX_W;

    line_meta_t          meta_q [LINES];
    logic [TAG_W-1:0]    tag_q  [LINES];
    logic [2*DATA_W-1:0] blk_q  [LINES];

    // Combinational read of the addressed line.
    always_comb begin
        meta_o = meta_q[idx];
        tag_o  = tag_q[idx];
        blk_o  = blk_q[idx];
    end

    // Line state update: reset clear, refill, reference and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                meta_q[i] <= '0;
                tag_q[i]  <= '0;
                blk_q[i]  <= '0;
            end
        end else begin
            if (fill_en) begin
                meta_q[idx].valid <= 1'b1;
                meta_q[idx].dirty <= 1'b0;
                tag_q[idx]        <= fill_tag;
                blk_q[idx]        <= fill_blk;
            end
            if (use_en)  meta_q[idx].refb <= 1'b1;
            if (clr_ref) meta_q[idx].refb <= 1'b0;
            if (wr_en) begin
                meta_q[idx].dirty <= 1'b1;
                if (wr_word) blk_q[idx][2*DATA_W-1:DATA_W] <= wr_data;
                else         blk_q[idx][DATA_W-1:0]        <= wr_data;
            end
        end
    end

    // R5
    ref_ops_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(use_en && clr_ref));

    // R3
    fill_makes_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> meta_q[$past(idx)].valid && !meta_q[$past(idx)].dirty);

    // R4
    write_marks_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> meta_q[$past(idx)].dirty);
endmodule

// File: rtl/victim_pick.sv
// Replacement choice for one index of a two-way cache. Invalid lines come
// first, with way 0 ahead of way 1. Next comes a way whose reference bit is
// clear. Way 0 is the fallback.
module victim_pick (
    input  logic [1:0] valid_i,
    input  logic [1:0] refb_i,
    output logic       victim_o
);
    // Priority selection of the way to replace.
    always_comb begin
        if (!valid_i[0])      victim_o = 1'b0;
        else if (!valid_i[1]) victim_o = 1'b1;
        else if (!refb_i[0])  victim_o = 1'b0;
        else if (!refb_i[1])  victim_o = 1'b1;
        else                  victim_o = 1'b0;
    end
endmodule

// File: rtl/nru_cache2w.sv
// Two-way set associative, write-back, write-allocate cache with one
// not-recently-used bit per line. Assumes the CPU holds its request and
// address stable until cpu_ready. Assumes memory answers each block
// request with a one-cycle mem_ack.
module nru_cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_req,
    input  logic                cpu_we,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic [DATA_W-1:0]   cpu_wdata,
    output logic [DATA_W-1:0]   cpu_rdata,
    output logic                cpu_ready,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [2*DATA_W-1:0] mem_wdata,
    input  logic [2*DATA_W-1:0] mem_rdata,
    input  logic                mem_ack
);
    localparam int TAG_W = ADDR_W - IDX_W - 1;
    localparam int WAYS  = 2;

    logic [IDX_W-1:0]    req_idx;
    logic [TAG_W-1:0]    req_tag;
    logic                req_word;
    line_meta_t          meta_v [WAYS];
    logic [TAG_W-1:0]    tag_v  [WAYS];
    logic [2*DATA_W-1:0] blk_v  [WAYS];
    logic [WAYS-1:0]     hit_v, use_v, clr_v, wr_v, fill_v, valid_v, refb_v;
    logic                hit, hit_way, victim;
    cstate_e             st_q;
    logic                vic_q;

    assign req_word = cpu_addr[0];
    assign req_idx  = cpu_addr[IDX_W:1];
    assign req_tag  = cpu_addr[ADDR_W-1:IDX_W+1];

    // One storage array per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx      (req_idx),
            .meta_o   (meta_v[w]),
            .tag_o    (tag_v[w]),
            .blk_o    (blk_v[w]),
            .fill_en  (fill_v[w]),
            .fill_tag (req_tag),
            .fill_blk (mem_rdata),
            .use_en   (use_v[w]),
            .clr_ref  (clr_v[w]),
            .wr_en    (wr_v[w]),
            .wr_word  (req_word),
            .wr_data  (cpu_wdata)
        );
        assign hit_v[w]   = meta_v[w].valid && (tag_v[w] == req_tag);
        assign valid_v[w] = meta_v[w].valid;
        assign refb_v[w]  = meta_v[w].refb;
        assign use_v[w]   = cpu_ready && (hit_way == 1'(w));
        assign clr_v[w]   = cpu_ready && (hit_way != 1'(w));
        assign wr_v[w]    = use_v[w] && cpu_we;
        assign fill_v[w]  = (st_q == ST_FILL) && mem_ack && (vic_q == 1'(w));
    end

    victim_pick u_pick (
        .valid_i  (valid_v),
        .refb_i   (refb_v),
        .victim_o (victim)
    );

    // Hit detection and read data selection.
    always_comb begin
        hit       = |hit_v;
        hit_way   = hit_v[1];
        cpu_ready = (st_q == ST_IDLE) && cpu_req && hit;
        cpu_rdata = req_word ? blk_v[hit_way][2*DATA_W-1:DATA_W]
                             : blk_v[hit_way][DATA_W-1:0];
    end

    // Memory port drive for write-back and refill.
    always_comb begin
        mem_req   = (st_q == ST_WBACK) || (st_q == ST_FILL);
        mem_we    = (st_q == ST_WBACK);
        mem_wdata = blk_v[vic_q];
        if (st_q == ST_WBACK) mem_addr = {tag_v[vic_q], req_idx, 1'b0};
        else                  mem_addr = {req_tag, req_idx, 1'b0};
    end

    // Miss sequencing: pick the victim, write it back if dirty, then refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            vic_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: if (cpu_req && !hit) begin
                    vic_q <= victim;
                    st_q  <= (meta_v[victim].valid && meta_v[victim].dirty)
                             ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ack) st_q <= ST_FILL;
                ST_FILL:  if (mem_ack) st_q <= ST_IDLE;
                default:  st_q <= ST_IDLE;
            endcase
        end
    end

    // R9
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_wdata));

    // R7
    wback_then_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we);

    // R3
    stall_during_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !cpu_ready);

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_req && !mem_req);

    // R5
    single_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(refb_v) <= 1);

    // R1
    block_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);
endmodule

// File: tb/tb_nru_cache2w.sv
// Self-checking bench: a reference cache model plus a delayed memory model.
module tb_nru_cache2w;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic        cpu_ready, mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [63:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nru_cache2w dut (.*);

    // memory model
    logic [31:0] mem [int unsigned];
    int mem_delay = 0, wait_cnt = 0;
    int wb_cnt = 0, rd_cnt = 0;
    logic [31:0] last_wb_addr, last_rd_addr;
    logic [63:0] last_wb_data;
    int order_err = 0;

    function automatic logic [31:0] mem_rd(logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
    endfunction

    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            if (wait_cnt >= mem_delay) begin
                wait_cnt = 0;
                mem_ack  = 1'b1;
                if (mem_we) begin
                    mem[mem_addr]     = mem_wdata[31:0];
                    mem[mem_addr + 1] = mem_wdata[63:32];
                    wb_cnt++;
                    last_wb_addr = mem_addr;
                    last_wb_data = mem_wdata;
                end else begin
                    mem_rdata = {mem_rd(mem_addr + 1), mem_rd(mem_addr)};
                    rd_cnt++;
                    last_rd_addr = mem_addr;
                end
            end else wait_cnt++;
        end
    end

    // reference model
    logic        m_v [2][8], m_d [2][8], m_r [2][8];
    logic [27:0] m_tag [2][8];
    logic [31:0] m_dat [2][8][2];

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(bit we, logic [31:0] addr, logic [31:0] wdata, string lbl);
        logic [2:0]  idx = addr[3:1];
        logic [27:0] tag = addr[31:4];
        logic        wd  = addr[0];
        int hw = -1, vic, cycles, wb0, rd0;
        bit exp_wb = 0;
        logic [31:0] wb_a, blk_a;
        logic [63:0] wb_d;
        logic [31:0] exp_rd;
        for (int w = 0; w < 2; w++) if (m_v[w][idx] && m_tag[w][idx] == tag) hw = w;
        blk_a = {tag, idx, 1'b0};
        if (hw < 0) begin
            // R6 victim order
            if (!m_v[0][idx]) vic = 0;
            else if (!m_v[1][idx]) vic = 1;
            else if (!m_r[0][idx]) vic = 0;
            else if (!m_r[1][idx]) vic = 1;
            else vic = 0;
            exp_wb = m_v[vic][idx] && m_d[vic][idx];
            wb_a = {m_tag[vic][idx], idx, 1'b0};
            wb_d = {m_dat[vic][idx][1], m_dat[vic][idx][0]};
        end
        wb0 = wb_cnt; rd0 = rd_cnt;
        @(negedge clk);
        cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wdata;
        #1;
        cycles = 0;
        while (!cpu_ready) begin
            @(negedge clk); #1; cycles++;
        end
        if (hw < 0) begin
            // model refill from memory (after any write-back)
            m_v[vic][idx] = 1; m_d[vic][idx] = 0; m_tag[vic][idx] = tag;
            m_dat[vic][idx][0] = mem_rd(blk_a);
            m_dat[vic][idx][1] = mem_rd(blk_a + 1);
            hw = vic;
        end
        exp_rd = m_dat[hw][idx][wd];
        if (!we) check(cpu_rdata == exp_rd, {"R1 read data ", lbl}, cpu_rdata, exp_rd);
        if (wb0 + rd0 == wb_cnt + rd_cnt && !exp_wb && cycles == 0) begin
            check(1, {"R2 hit ", lbl}, 0, 0);
        end else begin
            check(cycles > 0, {"R3 miss stall ", lbl}, cycles, 1);
            check(rd_cnt == rd0 + 1 && last_rd_addr == blk_a, {"R3 refill addr ", lbl},
                  last_rd_addr, blk_a);
            check(wb_cnt == wb0 + (exp_wb ? 1 : 0), {"R7 write-back count ", lbl},
                  wb_cnt - wb0, exp_wb);
            if (exp_wb)
                check(last_wb_addr == wb_a && last_wb_data == wb_d,
                      {"R7 write-back block ", lbl}, {last_wb_addr, last_wb_data[31:0]},
                      {wb_a, wb_d[31:0]});
        end
        // R5 and R4 model update on use
        m_r[hw][idx] = 1; m_r[1-hw][idx] = 0;
        if (we) begin m_dat[hw][idx][wd] = wdata; m_d[hw][idx] = 1; end
        @(negedge clk);
        cpu_req = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int w = 0; w < 2; w++)
            for (int i = 0; i < 8; i++) begin
                m_v[w][i] = 0; m_d[w][i] = 0; m_r[w][i] = 0; m_tag[w][i] = '0;
                m_dat[w][i][0] = '0; m_dat[w][i][1] = '0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R8 reset state
        check(!cpu_ready && !mem_req, "R8 idle after reset", {cpu_ready, mem_req}, 0);
        do_op(0, 32'h0000_0000, 0, "R8 first access misses, no write-back");
        // R6 invalid preference, R4 dirty, R5 ref flip, R7 ordered write-back
        do_op(1, 32'h0000_0015, 32'hAAAA_0001, "R6 fill way0");
        do_op(1, 32'h0000_0024, 32'hBBBB_0002, "R6 fill invalid way1");
        do_op(0, 32'h0000_0015, 0, "R5 hit A");
        do_op(0, 32'h0000_0015, 0, "R2 hit again");
        do_op(0, 32'h0000_0034, 0, "R6 evict not-recently-used way1");
        do_op(0, 32'h0000_0025, 0, "R7 evict dirty A");
        do_op(0, 32'h0000_0024, 0, "R4 written word back from memory");
        do_op(1, 32'h0000_0025, 32'h1234_5678, "R4 write hit");
        do_op(0, 32'h0000_0025, 0, "R1 upper word readback");
        do_op(0, 32'h0000_0024, 0, "R1 lower word readback");
        // random traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] a;
            a = {26'd0, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                 1'($urandom_range(0, 1))};
            mem_delay = $urandom_range(0, 3);
            do_op(1'($urandom_range(0, 1)), a, $urandom, "random");
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule